// File: doc/BRIEF.md
# Byte-Lane Bus Target with Handshake Acknowledge

This block is a memory-mapped target on an asynchronous 16-bit data, 24-bit address bus whose control lines are all active-low. A master places an address, sets the direction line, pulls the address strobe low and pulls one or both byte strobes low. The block brings those strobes into its own clock domain, checks whether the address falls inside its window, waits a fixed number of clocks and then pulls the acknowledge low. The master waits for that acknowledge however long it takes, so the block alone decides how long each word takes.

On a write, each byte lane whose strobe is low is stored into a small word-organised register file, and the other lane keeps its value. On a read, the block drives the addressed word and raises an output enable for as long as the selected read cycle lasts. The acknowledge stays low until the master lets go of the address strobe, and then it is released.

Top module: `strb_bus_slave`

## Requirements
- R1: The window is BASE_ADDR (default 0x010000) up to BASE_ADDR + 2*WORDS - 1 (default 32 bytes, 16 words). Address bit 0 is not decoded: byte addresses 2n and 2n+1 reach the same word. The word index is address bits [4:1] by default.
- R2: A write (rw_i = 0) with both uds_ni and lds_ni low stores data_i[15:8] and data_i[7:0] into the addressed word.
- R3: A write with only uds_ni low updates bits 15:8 of the word, and one with only lds_ni low updates bits 7:0. The other byte keeps its previous value.
- R4: With as_ni low, at least one byte strobe low and an address in the window, dtack_no goes low on the (SYNC_STAGES + WAIT_STATES + 1)-th rising clock edge after the strobes fall (default 6). rw_i = 1 selects a read.
- R5: Once low, dtack_no stays low for as long as as_ni stays low.
- R6: After as_ni rises, dtack_no returns high on the (SYNC_STAGES + 1)-th rising edge (default 3).
- R7: data_oe_o is high only during a selected read, from selection until release. While it is high, data_o carries the stored word at the address. While it is low, data_o is zero.
- R8: An address outside the window never produces an acknowledge and leaves the storage unchanged.
- R9: With as_ni low and both byte strobes high, no acknowledge is given.
- R10: If as_ni rises before the acknowledge, the cycle is dropped: no acknowledge is given and nothing is written.
- R11: After reset, dtack_no is high, data_oe_o is low and every stored word is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| as_ni | input | 1 | Address strobe, active low |
| rw_i | input | 1 | Direction: 1 read, 0 write |
| uds_ni | input | 1 | Upper byte strobe (bits 15:8), active low |
| lds_ni | input | 1 | Lower byte strobe (bits 7:0), active low |
| addr_i | input | 24 | Byte address |
| data_i | input | 16 | Write data |
| data_o | output | 16 | Read data, zero when not enabled |
| data_oe_o | output | 1 | Read data output enable |
| dtack_no | output | 1 | Transfer acknowledge, active low |

## Verification
Writes are issued with both strobes, with only the upper strobe and with only the lower strobe. They are aimed at the same word, so a lane that is wrongly enabled or wrongly held shows up as a corrupted byte on the next read. Odd and even addresses, the first and last word and the two addresses just outside the window separate bit-0 handling, boundary decode and aliasing. Cycles with no byte strobe, and cycles dropped before the acknowledge, separate qualification from plain address matching. A behavioural model predicts dtack_no, data_oe_o and data_o on every clock, which pins down both the acknowledge latency and the release latency.

// File: rtl/strb_pkg.sv
package strb_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_ACK  = 2'd2
  } cyc_state_e;
endpackage

// File: rtl/strb_sync.sv
module strb_sync #(
  parameter int unsigned WIDTH   = 1,
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [STAGES-1:0][WIDTH-1:0] stg_q;

  if (STAGES == 1) begin : g_single
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg_q <= {STAGES{{WIDTH{RST_VAL}}}};
      else         stg_q <= d_i;
    end
  end else begin : g_chain
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg_q <= {STAGES{{WIDTH{RST_VAL}}}};
      else         stg_q <= {stg_q[STAGES-2:0], d_i};
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/strb_decode.sv
module strb_decode #(
  parameter int unsigned       ADDR_W    = 24,
  parameter int unsigned       IDX_W     = 4,
  parameter int unsigned       LANE_W    = 1,
  parameter logic [ADDR_W-1:0] BASE_ADDR = '0
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic              hit_o,
  output logic [IDX_W-1:0]  idx_o
);
  localparam int unsigned OFS_W = IDX_W + LANE_W;

  logic unused_lane_bits;
  assign unused_lane_bits = ^addr_i[LANE_W-1:0];

  assign hit_o = (addr_i[ADDR_W-1:OFS_W] == BASE_ADDR[ADDR_W-1:OFS_W]);
  assign idx_o = addr_i[OFS_W-1:LANE_W];
endmodule

// File: rtl/strb_cycle_ctrl.sv
module strb_cycle_ctrl
  import strb_pkg::*;
#(
  parameter int unsigned WAIT_STATES = 3
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       as_act_i,
  input  logic       ds_act_i,
  input  logic       hit_i,
  output cyc_state_e state_o,
  output logic       commit_o,
  output logic       dtack_no
);
  localparam int unsigned CNT_W = $clog2(WAIT_STATES + 2);
  localparam logic [CNT_W-1:0] WAIT_LIM = CNT_W'(WAIT_STATES);

  cyc_state_e state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    unique case (state_q)
      ST_IDLE: begin
        if (as_act_i && ds_act_i && hit_i) begin
          cnt_d   = CNT_W'(1);
          state_d = (WAIT_STATES == 0) ? ST_ACK : ST_WAIT;
        end
      end
      ST_WAIT: begin
        if (!as_act_i)              state_d = ST_IDLE;  // master dropped the cycle
        else if (cnt_q == WAIT_LIM) state_d = ST_ACK;
        else                        cnt_d   = cnt_q + CNT_W'(1);
      end
      ST_ACK: begin
        if (!as_act_i) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assign state_o  = state_q;
  assign commit_o = (state_d == ST_ACK) && (state_q != ST_ACK);
  assign dtack_no = (state_q != ST_ACK);
endmodule

// File: rtl/strb_store.sv
module strb_store #(
  parameter int unsigned WORDS = 16,
  parameter int unsigned LANES = 2,
  parameter int unsigned IDX_W = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [LANES-1:0]   lane_we_i,
  input  logic [IDX_W-1:0]   idx_i,
  input  logic [LANES*8-1:0] wdata_i,
  output logic [LANES*8-1:0] rdata_o
);
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [7:0] lane_mem [WORDS];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        for (int w = 0; w < WORDS; w++) lane_mem[w] <= '0;
      end else if (lane_we_i[l]) begin
        lane_mem[idx_i] <= wdata_i[l*8 +: 8];
      end
    end

    assign rdata_o[l*8 +: 8] = lane_mem[idx_i];
  end
endmodule

// File: rtl/strb_bus_slave.sv
module strb_bus_slave
  import strb_pkg::*;
#(
  parameter int unsigned       ADDR_W      = 24,
  parameter int unsigned       DATA_W      = 16,
  parameter int unsigned       WORDS       = 16,
  parameter int unsigned       WAIT_STATES = 3,
  parameter int unsigned       SYNC_STAGES = 2,
  parameter logic [ADDR_W-1:0] BASE_ADDR   = 24'h01_0000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              as_ni,
  input  logic              rw_i,
  input  logic              uds_ni,
  input  logic              lds_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] data_o,
  output logic              data_oe_o,
  output logic              dtack_no
);
  localparam int unsigned LANES  = DATA_W / 8;
  localparam int unsigned LANE_W = $clog2(LANES);
  localparam int unsigned IDX_W  = $clog2(WORDS);

  logic as_n_s, rw_s, uds_n_s, lds_n_s;
  logic hit, commit;
  logic [IDX_W-1:0]  idx;
  logic [LANES-1:0]  lane_we;
  logic [DATA_W-1:0] rdata;
  cyc_state_e        state;

  strb_sync #(.WIDTH(4), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({as_ni, rw_i, uds_ni, lds_ni}),
    .q_o   ({as_n_s, rw_s, uds_n_s, lds_n_s})
  );

  strb_decode #(
    .ADDR_W(ADDR_W), .IDX_W(IDX_W), .LANE_W(LANE_W), .BASE_ADDR(BASE_ADDR)
  ) u_dec (
    .addr_i(addr_i),
    .hit_o (hit),
    .idx_o (idx)
  );

  strb_cycle_ctrl #(.WAIT_STATES(WAIT_STATES)) u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .as_act_i(!as_n_s),
    .ds_act_i(!uds_n_s || !lds_n_s),
    .hit_i   (hit),
    .state_o (state),
    .commit_o(commit),
    .dtack_no(dtack_no)
  );

  // lane 1 = upper byte, lane 0 = lower byte
  assign lane_we = {commit && !rw_s && !uds_n_s, commit && !rw_s && !lds_n_s};

  strb_store #(.WORDS(WORDS), .LANES(LANES), .IDX_W(IDX_W)) u_store (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .lane_we_i(lane_we),
    .idx_i    (idx),
    .wdata_i  (data_i),
    .rdata_o  (rdata)
  );

  assign data_oe_o = (state != ST_IDLE) && rw_s && !as_n_s;
  assign data_o    = data_oe_o ? rdata : '0;
endmodule

// File: rtl/strb_bus_slave_chk.sv
module strb_bus_slave_chk #(
  parameter int unsigned       ADDR_W    = 24,
  parameter int unsigned       DATA_W    = 16,
  parameter int unsigned       WORDS     = 16,
  parameter logic [ADDR_W-1:0] BASE_ADDR = '0
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic [DATA_W-1:0] data_o,
  input logic              data_oe_o,
  input logic              dtack_no,
  input logic              as_n_s
);
  localparam int unsigned OFS_W = $clog2(WORDS) + $clog2(DATA_W / 8);

  p_ack_in_window_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(dtack_no) |-> ((addr_i >> OFS_W) == (BASE_ADDR >> OFS_W)));

  p_ack_after_strobe_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(dtack_no) |-> !$past(as_n_s));

  p_ack_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!dtack_no && !as_n_s) |=> !dtack_no);

  p_ack_release_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!dtack_no && as_n_s) |=> dtack_no);

  p_quiet_bus_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !data_oe_o |-> (data_o == '0));
endmodule

bind strb_bus_slave strb_bus_slave_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .WORDS(WORDS), .BASE_ADDR(BASE_ADDR)
) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .addr_i   (addr_i),
  .data_o   (data_o),
  .data_oe_o(data_oe_o),
  .dtack_no (dtack_no),
  .as_n_s   (as_n_s)
);

// File: tb/strb_bus_slave_tb_top.sv
module strb_bus_slave_tb_top;
  localparam int          SYNC  = 2;
  localparam int          WS    = 3;
  localparam int          WORDS = 16;
  localparam logic [23:0] BASE  = 24'h01_0000;
  localparam int          LAT   = SYNC + WS + 1;
  localparam int          REL   = SYNC + 1;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic as_n = 1'b1, rw = 1'b1, uds_n = 1'b1, lds_n = 1'b1;
  logic [23:0] addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] data_o;
  logic data_oe_o, dtack_no;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #2 clk_i = ~clk_i;

  strb_bus_slave dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .as_ni(as_n), .rw_i(rw),
    .uds_ni(uds_n), .lds_ni(lds_n), .addr_i(addr), .data_i(wdata),
    .data_o(data_o), .data_oe_o(data_oe_o), .dtack_no(dtack_no)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // ---------------- behavioural reference ----------------
  typedef struct { bit as_n; bit rw; bit uds_n; bit lds_n; } snap_t;
  snap_t dq[$];
  bit m_busy, m_ack;
  int m_waited;
  logic [15:0] m_mem [WORDS];

  function automatic bit in_win(logic [23:0] a);
    return (a >= BASE) && (a < BASE + 24'(2 * WORDS));
  endfunction
  function automatic int widx(logic [23:0] a);
    return int'((a - BASE) >> 1) % WORDS;
  endfunction

  task automatic m_commit(snap_t s);
    if (!s.rw) begin
      if (!s.uds_n) m_mem[widx(addr)][15:8] = wdata[15:8];
      if (!s.lds_n) m_mem[widx(addr)][7:0]  = wdata[7:0];
    end
  endtask

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dq.delete();
      for (int i = 0; i < SYNC; i++) dq.push_back('{1'b1, 1'b1, 1'b1, 1'b1});
      m_busy = 0; m_ack = 0; m_waited = 0;
      for (int i = 0; i < WORDS; i++) m_mem[i] = '0;
    end else begin
      snap_t seen;
      seen = dq.pop_front();
      dq.push_back('{as_n, rw, uds_n, lds_n});
      if (!m_busy) begin
        if (!seen.as_n && (!seen.uds_n || !seen.lds_n) && in_win(addr)) begin
          m_busy = 1; m_waited = 0;
          if (WS == 0) begin m_ack = 1; m_commit(seen); end
        end
      end else if (seen.as_n) begin
        m_busy = 0; m_ack = 0;
      end else if (!m_ack) begin
        m_waited++;
        if (m_waited == WS) begin m_ack = 1; m_commit(seen); end
      end
    end
  end

  always @(posedge clk_i) begin
    #1;
    if (rst_ni && !done) begin
      bit e_oe;
      e_oe = m_busy && !dq[0].as_n && dq[0].rw;
      chk(dtack_no == !m_ack, "R4", "model dtack", dtack_no, !m_ack);
      chk(data_oe_o == e_oe, "R7", "model oe", data_oe_o, e_oe);
      chk(data_o == (e_oe ? m_mem[widx(addr)] : 16'h0), "R7", "model data",
          data_o, e_oe ? m_mem[widx(addr)] : 16'h0);
    end
  end

  // ---------------- directed stimulus ----------------
  task automatic bus_cycle(input logic [23:0] a, input bit rd, input bit u, input bit l,
                           input logic [15:0] d, output logic [15:0] q);
    int k;
    @(negedge clk_i);
    addr = a; wdata = d; rw = rd; as_n = 0; uds_n = !u; lds_n = !l;
    k = 0;
    do begin @(negedge clk_i); k++; end while (dtack_no && k < 40);
    chk(k == LAT, "R4", "ack latency", k, LAT);
    q = data_o;
    chk(data_oe_o == rd, "R7", "oe during cycle", data_oe_o, rd);
    repeat (2) @(negedge clk_i);
    chk(dtack_no == 1'b0, "R5", "ack held", dtack_no, 0);
    as_n = 1; uds_n = 1; lds_n = 1;
    k = 0;
    do begin @(negedge clk_i); k++; end while (!dtack_no && k < 40);
    chk(k == REL, "R6", "release latency", k, REL);
    chk(data_oe_o == 1'b0, "R7", "oe after release", data_oe_o, 0);
  endtask

  task automatic no_ack(input logic [23:0] a, input bit rd, input bit u, input bit l,
                        input int n, input string req);
    bit seen_ack;
    @(negedge clk_i);
    addr = a; wdata = 16'hDEAD; rw = rd; as_n = 0; uds_n = !u; lds_n = !l;
    seen_ack = 0;
    repeat (n) begin @(negedge clk_i); if (!dtack_no) seen_ack = 1; end
    as_n = 1; uds_n = 1; lds_n = 1;
    repeat (REL + 3) begin @(negedge clk_i); if (!dtack_no) seen_ack = 1; end
    chk(!seen_ack, req, "no ack", seen_ack, 0);
  endtask

  initial begin
    logic [15:0] q;
    repeat (3) @(negedge clk_i);
    chk(dtack_no == 1'b1, "R11", "reset dtack", dtack_no, 1);
    chk(data_oe_o == 1'b0, "R11", "reset oe", data_oe_o, 0);
    rst_ni = 1;
    repeat (2) @(negedge clk_i);

    bus_cycle(BASE + 24'd30, 1, 1, 1, '0, q);
    chk(q == 16'h0, "R11", "last word zero after reset", q, 0);

    bus_cycle(BASE + 24'd4, 0, 1, 1, 16'hA5C3, q);
    bus_cycle(BASE + 24'd4, 1, 1, 1, '0, q);
    chk(q == 16'hA5C3, "R2", "full word write", q, 16'hA5C3);

    bus_cycle(BASE + 24'd4, 0, 1, 0, 16'h11FF, q);
    bus_cycle(BASE + 24'd4, 1, 1, 1, '0, q);
    chk(q == 16'h11C3, "R3", "upper lane only", q, 16'h11C3);

    bus_cycle(BASE + 24'd5, 0, 0, 1, 16'hEE22, q);
    bus_cycle(BASE + 24'd4, 1, 1, 1, '0, q);
    chk(q == 16'h1122, "R3", "lower lane only via odd addr", q, 16'h1122);
    bus_cycle(BASE + 24'd5, 1, 0, 1, '0, q);
    chk(q == 16'h1122, "R1", "odd address aliases word", q, 16'h1122);

    bus_cycle(BASE + 24'd30, 0, 1, 1, 16'h5A0F, q);
    bus_cycle(BASE + 24'd31, 1, 1, 1, '0, q);
    chk(q == 16'h5A0F, "R1", "last word in window", q, 16'h5A0F);

    no_ack(BASE + 24'd32, 0, 1, 1, 20, "R8");
    no_ack(BASE - 24'd2, 0, 1, 1, 20, "R8");
    no_ack(BASE + 24'h10_0000, 1, 1, 1, 20, "R8");
    bus_cycle(BASE, 1, 1, 1, '0, q);
    chk(q == 16'h0, "R8", "no aliased write at word 0", q, 0);
    bus_cycle(BASE + 24'd30, 1, 1, 1, '0, q);
    chk(q == 16'h5A0F, "R8", "last word untouched", q, 16'h5A0F);

    no_ack(BASE + 24'd8, 0, 0, 0, 15, "R9");
    no_ack(BASE + 24'd6, 0, 1, 1, 2, "R10");
    bus_cycle(BASE + 24'd6, 1, 1, 1, '0, q);
    chk(q == 16'h0, "R10", "dropped write left no data", q, 0);
    bus_cycle(BASE + 24'd8, 1, 1, 1, '0, q);
    chk(q == 16'h0, "R9", "unstrobed cycle left no data", q, 0);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog run did not complete");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule